// File: doc/BRIEF.md
# Bus-Programmable Watchdog Countdown Timer

This block is a watchdog timer attached to a zero-wait-state APB slave port. Software writes a start value, turns the timer on and then must keep servicing it. Each pulse on the tick-enable input moves the count down by one. Because the tick-enable comes from a divided system clock, the counting rate follows any change to that divider, and the count carries on from where it was when the rate changes.

When the count reaches zero, a raw status bit is set and the interrupt output rises if interrupts are enabled. On the following tick the count reloads from the start value. A write of any data to the clear register drops the status bit and restarts the count at once. If a second timeout arrives while the status bit is still set and the reset-enable control bit is on, the block gives a one-cycle reset pulse. A key register can lock the writable registers against stray writes.

Top module: `wdt_apb`

## Requirements
- R1: After reset the raw status (0x010), lock status (0xC00), control (0x008), `irq` and `wdt_reset` all read 0. The count (0x004) and the start value (0x000) read 0xFFFFFFFF.
- R2: `pready` is always 1 and `pslverr` is always 0. A read of any offset other than 0x000, 0x004, 0x008, 0x010, 0x014 or 0xC00 returns 0.
- R3: When control bit 0 is 1, each `tick_en` pulse lowers the count (0x004) by one. When control bit 0 is 0, ticks leave the count unchanged. The count holds between ticks, so a change in tick spacing changes only the rate.
- R4: On the tick that takes the count from 1 to 0, raw status bit 0 (0x010) becomes 1 and the count reads 0.
- R5: On the next enabled tick after the count reads 0, the count reloads from the start value.
- R6: A write of any data to the clear register (0x00C) sets raw status to 0 and reloads the count from the start value, both visible on the next read.
- R7: A write to the start-value register (0x000) also loads the written value into the count immediately.
- R8: The masked status (0x014) equals raw status AND control bit 0, and `irq` equals the masked status.
- R9: When the count reaches 0 while raw status is already 1 and control bit 1 is 1, `wdt_reset` is high for exactly one clock cycle. When control bit 1 is 0, no pulse occurs.
- R10: A write of 0x1ACCE551 to 0xC00 unlocks the registers and any other value locks them. 0xC00 reads 1 when locked and 0 when unlocked. While locked, writes to 0x000, 0x008 and 0x00C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tick_en | input | 1 | One-cycle count-enable pulse from the clock divider |
| irq | output | 1 | Interrupt, equal to masked status |
| wdt_reset | output | 1 | One-cycle reset request on a second unserviced timeout |

## Verification
Every register write takes effect at the clock edge that ends the APB access phase. A read presents the register state from before that edge, so a read placed after a write sees the write's result with no further delay. A tick pulse changes the count, the status bit and `wdt_reset` at the edge where `tick_en` is sampled high, and `wdt_reset` falls again at the next edge. The bench drives ticks and bus phases at falling edges and samples at falling edges, so each result is read one half-cycle after the edge that produced it. Read results go through an expected-value queue that a monitor process drains, and the reset pulses are counted at every falling edge to check both their number and their width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned CTRL_W = 2;
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_RST_BIT = 1;

    localparam logic [ADDR_W-1:0] OFS_START = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_KEY   = 12'hC00;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     start_val,
    output logic [CTRL_W-1:0] ctrl,
    output logic              locked,
    output logic              reload,
    output logic [DW-1:0]     reload_val,
    output logic              clear
);
    typedef struct packed {
        logic [DW-1:0]     start;
        logic [CTRL_W-1:0] ctrl;
        logic              locked;
    } rf_t;

    rf_t rf_d, rf_q;
    logic wr_ok;

    always_comb begin
        rf_d       = rf_q;
        wr_ok      = wr_en && !rf_q.locked;
        reload     = 1'b0;
        reload_val = rf_q.start;
        clear      = 1'b0;
        if (wr_en && wr_addr == OFS_KEY) begin
            rf_d.locked = (wr_data[31:0] != UNLOCK_KEY);
        end
        if (wr_ok) begin
            unique case (wr_addr)
                OFS_START: begin
                    rf_d.start = wr_data;
                    reload     = 1'b1;
                    reload_val = wr_data;
                end
                OFS_CTRL:  rf_d.ctrl = wr_data[CTRL_W-1:0];
                OFS_CLEAR: begin
                    clear  = 1'b1;
                    reload = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.start  <= '1;
            rf_q.ctrl   <= '0;
            rf_q.locked <= 1'b0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign start_val = rf_q.start;
    assign ctrl      = rf_q.ctrl;
    assign locked    = rf_q.locked;

    assert_locked_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && wr_addr == OFS_START) |=> $stable(start_val));
    assert_locked_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && wr_addr == OFS_CTRL) |=> $stable(ctrl));
    assert_key_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_KEY && wr_data[31:0] == UNLOCK_KEY) |=> !locked);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          rst_arm,
    input  logic [DW-1:0] start_val,
    input  logic          reload,
    input  logic [DW-1:0] reload_val,
    input  logic          clear,
    output logic [DW-1:0] count,
    output logic          raw,
    output logic          rst_pulse
);
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          raw;
        logic          rst;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        if (reload) begin
            st_d.cnt = reload_val;
            if (clear) st_d.raw = 1'b0;
        end else if (tick && run) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = start_val;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
                if (st_q.cnt == ONE) begin
                    st_d.raw = 1'b1;
                    st_d.rst = st_q.raw && rst_arm;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.raw <= 1'b0;
            st_q.rst <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count     = st_q.cnt;
    assign raw       = st_q.raw;
    assign rst_pulse = st_q.rst;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && run) && !reload) |=> $stable(count));
    assert_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !reload && count == ONE) |=> (raw && count == '0));
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !reload && count == '0) |=> (count == $past(start_val)));
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && clear) |=> (!raw && count == $past(reload_val)));
    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);
endmodule

// File: rtl/wdt_apb.sv
module wdt_apb
    import wdt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_en,
    output logic              irq,
    output logic              wdt_reset
);
    logic              wr_en;
    logic [DW-1:0]     start_val;
    logic [CTRL_W-1:0] ctrl;
    logic              locked;
    logic              reload;
    logic [DW-1:0]     reload_val;
    logic              clear;
    logic [DW-1:0]     count;
    logic              raw;
    logic              masked;

    assign wr_en = psel && penable && pwrite;

    wdt_regfile #(.DW(DW)) u_rf (
        .clk        (pclk),
        .rst_n      (presetn),
        .wr_en      (wr_en),
        .wr_addr    (paddr),
        .wr_data    (pwdata),
        .start_val  (start_val),
        .ctrl       (ctrl),
        .locked     (locked),
        .reload     (reload),
        .reload_val (reload_val),
        .clear      (clear)
    );

    wdt_core #(.DW(DW)) u_core (
        .clk        (pclk),
        .rst_n      (presetn),
        .tick       (tick_en),
        .run        (ctrl[CTRL_EN_BIT]),
        .rst_arm    (ctrl[CTRL_RST_BIT]),
        .start_val  (start_val),
        .reload     (reload),
        .reload_val (reload_val),
        .clear      (clear),
        .count      (count),
        .raw        (raw),
        .rst_pulse  (wdt_reset)
    );

    assign masked  = raw && ctrl[CTRL_EN_BIT];
    assign irq     = masked;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (paddr)
                OFS_START: prdata = start_val;
                OFS_COUNT: prdata = count;
                OFS_CTRL:  prdata = DW'(ctrl);
                OFS_RAW:   prdata = DW'(raw);
                OFS_MASK:  prdata = DW'(masked);
                OFS_KEY:   prdata = DW'(locked);
                default:   prdata = '0;
            endcase
        end
    end

    assert_irq_mask_R8: assert property (@(posedge pclk) disable iff (!presetn)
        (!ctrl[CTRL_EN_BIT]) |-> !irq);
    assert_reset_needs_raw_R9: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(wdt_reset) |-> $past(raw));
endmodule

// File: tb/wdt_apb_test.sv
module wdt_apb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, tick_en = 1'b0, irq, wdt_reset;

    int total = 0;
    int bad   = 0;
    int rst_seen = 0;
    int rst_wide = 0;
    logic rst_prev = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        mon_valid = 1'b0;
    logic [31:0] mon_data = '0;

    always #2 clk = ~clk;

    wdt_apb uut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .tick_en(tick_en),
        .irq(irq), .wdt_reset(wdt_reset)
    );

    // monitor: pops expected read data as each read completes
    always @(posedge clk) begin
        if (mon_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL %s: read %h with no expected item", "scoreboard", mon_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (mon_data !== e) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", t, mon_data, e);
                end
            end
        end
    end

    // reset pulse counter and width monitor (R9)
    always @(negedge clk) begin
        if (wdt_reset) rst_seen++;
        if (wdt_reset && rst_prev) rst_wide++;
        rst_prev = wdt_reset;
    end

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        mon_data  = prdata;
        mon_valid = 1'b1;
        @(negedge clk);
        mon_valid = 1'b0;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic ticks(input int n, input int period);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            repeat (period - 2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 wdt_reset", {31'd0, wdt_reset}, 32'd0);
        rd(12'h010, 32'd0, "R1 raw");
        rd(12'hC00, 32'd0, "R1 lock");
        rd(12'h008, 32'd0, "R1 ctrl");
        rd(12'h004, 32'hFFFF_FFFF, "R1 count");
        rd(12'h000, 32'hFFFF_FFFF, "R1 start");

        // R7 start write loads the count
        wr(12'h000, 32'd1000);
        rd(12'h004, 32'd1000, "R7 count after start write");
        // R3 ticks ignored while disabled
        ticks(5, 4);
        rd(12'h004, 32'd1000, "R3 disabled hold");

        // R3 counting across a rate change
        wr(12'h008, 32'd1);
        ticks(500, 16);
        rd(12'h004, 32'd500, "R3 count after 500 ticks");
        rd(12'h010, 32'd0, "R3 raw still clear");
        ticks(499, 8);
        rd(12'h004, 32'd1, "R3 count after rate change");
        ticks(1, 8);
        rd(12'h004, 32'd0, "R4 count at zero");
        rd(12'h010, 32'd1, "R4 raw set");
        rd(12'h014, 32'd1, "R8 masked set");
        check("R8 irq high", {31'd0, irq}, 32'd1);
        ticks(1, 8);
        rd(12'h004, 32'd1000, "R5 reload after zero");
        ticks(500, 4);
        rd(12'h004, 32'd500, "R5 count after reload");
        rd(12'h010, 32'd1, "R6 raw before clear");
        wr(12'h00C, 32'h0000_DEAD);
        rd(12'h004, 32'd1000, "R6 count after clear");
        rd(12'h010, 32'd0, "R6 raw after clear");
        check("R6 irq low", {31'd0, irq}, 32'd0);

        // R8 masking
        wr(12'h000, 32'd2);
        ticks(2, 3);
        wr(12'h008, 32'd0);
        rd(12'h010, 32'd1, "R8 raw with mask off");
        rd(12'h014, 32'd0, "R8 masked off");
        check("R8 irq masked", {31'd0, irq}, 32'd0);

        // R9 reset pulse on second timeout
        wr(12'h008, 32'd3);
        wr(12'h00C, 32'd0);
        ticks(2, 3);
        check("R9 no pulse on first timeout", rst_seen, 0);
        ticks(1, 3);
        ticks(2, 3);
        check("R9 one pulse on second timeout", rst_seen, 1);
        check("R9 pulse width one cycle", rst_wide, 0);
        wr(12'h008, 32'd1);
        ticks(3, 3);
        check("R9 no pulse with arm off", rst_seen, 1);

        // R10 lock
        wr(12'hC00, 32'd5);
        rd(12'hC00, 32'd1, "R10 locked");
        wr(12'h00C, 32'd0);
        rd(12'h010, 32'd1, "R10 clear ignored");
        rd(12'h004, 32'd0, "R10 count untouched by clear");
        wr(12'h000, 32'd77);
        rd(12'h000, 32'd2, "R10 start write ignored");
        rd(12'h004, 32'd0, "R10 count untouched by start");
        wr(12'h008, 32'd0);
        rd(12'h008, 32'd1, "R10 ctrl write ignored");
        wr(12'hC00, 32'h1ACC_E551);
        rd(12'hC00, 32'd0, "R10 unlocked");
        wr(12'h000, 32'd77);
        rd(12'h004, 32'd77, "R10 start write after unlock");

        // R2 bus response and unmapped reads
        check("R2 pready", {31'd0, pready}, 32'd1);
        check("R2 pslverr", {31'd0, pslverr}, 32'd0);
        rd(12'h020, 32'd0, "R2 unmapped 0x020");
        rd(12'h800, 32'd0, "R2 unmapped 0x800");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule